// File: doc/BRIEF.md
# Out-of-Order Completion Buffer with Per-Slot Lifecycle

This block is a circular buffer that tracks in-flight instructions for a speculative core that executes out of order. Decode writes each instruction into the slot at the tail and gets back that slot's index as the instruction's tag. Each slot holds an opcode, a destination register number and two operand fields. Each operand field is either a ready value or the tag of the slot that will produce it. A slot whose operands are both ready is offered to the arithmetic port or to the memory port, chosen by its opcode. Results come back on two writeback buses. The buffer stores each result in its slot and broadcasts it to every slot still waiting on that tag.

Slots retire strictly from the head. A finished slot writes its result to the register file. A slot cancelled by a branch misprediction is released without a write. A branch redirect cancels every slot younger than the branch tag. The slot lifecycle has five states: EMPTY, WAITING, DISPATCHED, DONE and KILLED. The transitions are as follows:
- insert moves EMPTY to WAITING.
- issue acceptance moves WAITING to DISPATCHED.
- writeback moves DISPATCHED to DONE.
- kill moves WAITING, DISPATCHED or DONE to KILLED.
- retirement moves DONE or KILLED to EMPTY.

Kill takes priority over issue and writeback in the same cycle. Retirement takes priority over kill. The depth must be a power of two.

Top module: `rob_core`

## Requirements
- R1: After reset every slot is EMPTY, ins_ready is 1, ins_tag is 0, and alu_issue_valid, mem_issue_valid, retire_valid and rf_we are all 0.
- R2: An insert (ins_valid with ins_ready) fills the slot numbered ins_tag, and ins_tag then advances by one modulo DEPTH. ins_ready is 0 while DEPTH slots are occupied, and a refused insert leaves ins_tag unchanged.
- R3: An operand with its ready flag at 1 carries a value. With the flag at 0, its low $clog2(DEPTH) bits name the producer slot. A slot is offered for issue only when both of its operands are ready.
- R4: A ready WAITING slot whose opcode bit OPW-1 is 0 is offered on the arithmetic port, and one with that bit at 1 on the memory port. Each port offers the oldest such slot counted from the head. When the offer is acknowledged, the slot becomes DISPATCHED and is never offered again.
- R5: A writeback whose tag names a DISPATCHED slot stores the data in that slot and makes it DONE.
- R6: A writeback replaces the producer tag with the written data in every not-ready operand that holds that tag.
- R7: An insert whose operand names a producer that is written back in the same cycle captures the written data. An insert whose operand names a producer that is already DONE captures that producer's stored result.
- R8: When the head slot is DONE, retire_valid and rf_we are 1 with rf_waddr and rf_wdata set to the slot's destination and result, and the head advances. Retirement is idle while the head slot is neither DONE nor KILLED, even if younger slots are DONE.
- R9: kill_valid makes every occupied slot younger than kill_tag KILLED. This takes priority over an issue acknowledge in the same cycle. KILLED slots are never offered and ignore writebacks, and they retire with retire_valid 1 and rf_we 0. ins_ready is 0 while kill_valid is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Decode presents an instruction |
| ins_op | input | OPW | Opcode; top bit selects memory port |
| ins_dst | input | RAW | Destination register number |
| ins_a_rdy | input | 1 | Operand A holds a value (1) or producer tag (0) |
| ins_a_val | input | DW | Operand A value or tag |
| ins_b_rdy | input | 1 | Operand B holds a value (1) or producer tag (0) |
| ins_b_val | input | DW | Operand B value or tag |
| ins_ready | output | 1 | Insert accepted this cycle |
| ins_tag | output | $clog2(DEPTH) | Tag given to the next inserted instruction |
| alu_issue_valid | output | 1 | Arithmetic port offer |
| alu_issue_tag | output | $clog2(DEPTH) | Offered slot |
| alu_issue_op | output | OPW | Offered opcode |
| alu_issue_a | output | DW | Offered operand A |
| alu_issue_b | output | DW | Offered operand B |
| alu_issue_ack | input | 1 | Arithmetic unit takes the offer |
| mem_issue_valid | output | 1 | Memory port offer |
| mem_issue_tag | output | $clog2(DEPTH) | Offered slot |
| mem_issue_op | output | OPW | Offered opcode |
| mem_issue_a | output | DW | Offered operand A |
| mem_issue_b | output | DW | Offered operand B |
| mem_issue_ack | input | 1 | Memory unit takes the offer |
| alu_wb_valid | input | 1 | Arithmetic result valid |
| alu_wb_tag | input | $clog2(DEPTH) | Arithmetic result slot |
| alu_wb_data | input | DW | Arithmetic result |
| mem_wb_valid | input | 1 | Memory result valid |
| mem_wb_tag | input | $clog2(DEPTH) | Memory result slot |
| mem_wb_data | input | DW | Memory result |
| kill_valid | input | 1 | Branch redirect |
| kill_tag | input | $clog2(DEPTH) | Mispredicted branch slot |
| rf_we | output | 1 | Register file write |
| rf_waddr | output | RAW | Register file write address |
| rf_wdata | output | DW | Register file write data |
| retire_valid | output | 1 | Head slot is released this cycle |

## Verification
The bench uses the default parameters: DEPTH 8, DW 16, OPW 4 and RAW 5. With eight slots, a short run wraps both pointers past the top index. One kill scenario spans the wrap point, so the younger-than comparison is exercised across the modular boundary. The bench also fills all eight slots to reach the full-refusal case. Four-bit opcodes let both issue ports run side by side. Sixteen-bit data keeps forwarded values distinct from producer tags.

// File: rtl/rob_pkg.sv
package rob_pkg;
    typedef enum logic [2:0] {
        ST_EMPTY,
        ST_WAIT,
        ST_DISP,
        ST_KILL,
        ST_DONE
    } rob_st_e;
endpackage

// File: rtl/rob_ring.sv
module rob_ring #(
    parameter int DEPTH = 8,
    parameter int TW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    output logic [TW-1:0] head,
    output logic [TW-1:0] tail,
    output logic [CW-1:0] occ,
    output logic          full
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head <= '0;
            tail <= '0;
            occ  <= '0;
        end else begin
            if (push) tail <= tail + 1'b1;
            if (pop)  head <= head + 1'b1;
            if (push && !pop)      occ <= occ + 1'b1;
            else if (pop && !push) occ <= occ - 1'b1;
        end
    end

    assign full = (occ == CW'(DEPTH));
endmodule

// File: rtl/rob_oldest.sv
module rob_oldest #(
    parameter int N  = 8,
    parameter int TW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [TW-1:0] base,
    output logic          hit,
    output logic [TW-1:0] sel
);
    logic [TW-1:0] probe;

    always_comb begin
        hit   = 1'b0;
        sel   = base;
        probe = base;
        for (int k = 0; k < N; k++) begin
            probe = base + TW'(k);
            if (!hit && req[probe]) begin
                hit = 1'b1;
                sel = probe;
            end
        end
    end
endmodule

// File: rtl/rob_slot.sv
module rob_slot
    import rob_pkg::*;
#(
    parameter int DW  = 16,
    parameter int OPW = 4,
    parameter int RAW = 5,
    parameter int TW  = 3,
    parameter int IDX = 0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ins_we,
    input  logic [OPW-1:0] ins_op,
    input  logic [RAW-1:0] ins_dst,
    input  logic           ins_av,
    input  logic [DW-1:0]  ins_ad,
    input  logic           ins_bv,
    input  logic [DW-1:0]  ins_bd,
    input  logic           wa_v,
    input  logic [TW-1:0]  wa_tag,
    input  logic [DW-1:0]  wa_d,
    input  logic           wm_v,
    input  logic [TW-1:0]  wm_tag,
    input  logic [DW-1:0]  wm_d,
    input  logic           disp_go,
    input  logic           kill_go,
    input  logic           cmt_go,
    output rob_st_e        st,
    output logic [OPW-1:0] op,
    output logic [RAW-1:0] dst,
    output logic           av,
    output logic [DW-1:0]  ad,
    output logic           bv,
    output logic [DW-1:0]  bd,
    output logic [DW-1:0]  res
);
    localparam logic [TW-1:0] MY_TAG = TW'(IDX);

    rob_st_e st_q, st_d;
    logic    hit_a, hit_m;

    assign hit_a = wa_v && (wa_tag == MY_TAG);
    assign hit_m = wm_v && (wm_tag == MY_TAG);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_EMPTY;
        else        st_q <= st_d;
    end

    // next-state selection
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_EMPTY: if (ins_we) st_d = ST_WAIT;
            ST_WAIT: begin
                if (kill_go)      st_d = ST_KILL;
                else if (disp_go) st_d = ST_DISP;
            end
            ST_DISP: begin
                if (kill_go)             st_d = ST_KILL;
                else if (hit_a || hit_m) st_d = ST_DONE;
            end
            ST_DONE: begin
                if (cmt_go)       st_d = ST_EMPTY;
                else if (kill_go) st_d = ST_KILL;
            end
            ST_KILL: if (cmt_go) st_d = ST_EMPTY;
        endcase
    end

    // payload and operand wakeup
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op  <= '0;
            dst <= '0;
            av  <= 1'b0;
            ad  <= '0;
            bv  <= 1'b0;
            bd  <= '0;
            res <= '0;
        end else if (ins_we) begin
            op  <= ins_op;
            dst <= ins_dst;
            av  <= ins_av;
            ad  <= ins_ad;
            bv  <= ins_bv;
            bd  <= ins_bd;
        end else begin
            if (!av) begin
                if (wa_v && wa_tag == ad[TW-1:0]) begin
                    av <= 1'b1;
                    ad <= wa_d;
                end else if (wm_v && wm_tag == ad[TW-1:0]) begin
                    av <= 1'b1;
                    ad <= wm_d;
                end
            end
            if (!bv) begin
                if (wa_v && wa_tag == bd[TW-1:0]) begin
                    bv <= 1'b1;
                    bd <= wa_d;
                end else if (wm_v && wm_tag == bd[TW-1:0]) begin
                    bv <= 1'b1;
                    bd <= wm_d;
                end
            end
            if (st_q == ST_DISP && !kill_go) begin
                if (hit_a)      res <= wa_d;
                else if (hit_m) res <= wm_d;
            end
        end
    end

    assign st = st_q;
endmodule

// File: rtl/rob_core.sv
module rob_core
    import rob_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int DW    = 16,
    parameter int OPW   = 4,
    parameter int RAW   = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ins_valid,
    input  logic [OPW-1:0]           ins_op,
    input  logic [RAW-1:0]           ins_dst,
    input  logic                     ins_a_rdy,
    input  logic [DW-1:0]            ins_a_val,
    input  logic                     ins_b_rdy,
    input  logic [DW-1:0]            ins_b_val,
    output logic                     ins_ready,
    output logic [$clog2(DEPTH)-1:0] ins_tag,
    output logic                     alu_issue_valid,
    output logic [$clog2(DEPTH)-1:0] alu_issue_tag,
    output logic [OPW-1:0]           alu_issue_op,
    output logic [DW-1:0]            alu_issue_a,
    output logic [DW-1:0]            alu_issue_b,
    input  logic                     alu_issue_ack,
    output logic                     mem_issue_valid,
    output logic [$clog2(DEPTH)-1:0] mem_issue_tag,
    output logic [OPW-1:0]           mem_issue_op,
    output logic [DW-1:0]            mem_issue_a,
    output logic [DW-1:0]            mem_issue_b,
    input  logic                     mem_issue_ack,
    input  logic                     alu_wb_valid,
    input  logic [$clog2(DEPTH)-1:0] alu_wb_tag,
    input  logic [DW-1:0]            alu_wb_data,
    input  logic                     mem_wb_valid,
    input  logic [$clog2(DEPTH)-1:0] mem_wb_tag,
    input  logic [DW-1:0]            mem_wb_data,
    input  logic                     kill_valid,
    input  logic [$clog2(DEPTH)-1:0] kill_tag,
    output logic                     rf_we,
    output logic [RAW-1:0]           rf_waddr,
    output logic [DW-1:0]            rf_wdata,
    output logic                     retire_valid
);
    localparam int TW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    rob_st_e        st_arr  [DEPTH];
    logic [OPW-1:0] op_arr  [DEPTH];
    logic [RAW-1:0] dst_arr [DEPTH];
    logic           av_arr  [DEPTH];
    logic [DW-1:0]  ad_arr  [DEPTH];
    logic           bv_arr  [DEPTH];
    logic [DW-1:0]  bd_arr  [DEPTH];
    logic [DW-1:0]  res_arr [DEPTH];

    logic [DEPTH-1:0] ins_we, disp_go, kill_go, cmt_go;
    logic [DEPTH-1:0] alu_req, mem_req;

    logic [TW-1:0] head, tail, koff;
    logic [CW-1:0] occ;
    logic          full, push, pop;
    logic          alu_hit, mem_hit;
    logic [TW-1:0] alu_sel, mem_sel;

    // operand resolution at insert: index 0 is A, index 1 is B
    logic          opv_in  [2];
    logic [DW-1:0] opd_in  [2];
    logic          opv_res [2];
    logic [DW-1:0] opd_res [2];

    rob_ring #(.DEPTH(DEPTH), .TW(TW), .CW(CW)) u_ring (
        .clk  (clk),
        .rst_n(rst_n),
        .push (push),
        .pop  (pop),
        .head (head),
        .tail (tail),
        .occ  (occ),
        .full (full)
    );

    assign ins_ready = !full && !kill_valid;
    assign push      = ins_valid && ins_ready;
    assign ins_tag   = tail;

    assign opv_in[0] = ins_a_rdy;
    assign opd_in[0] = ins_a_val;
    assign opv_in[1] = ins_b_rdy;
    assign opd_in[1] = ins_b_val;

    always_comb begin
        for (int j = 0; j < 2; j++) begin
            opv_res[j] = opv_in[j];
            opd_res[j] = opd_in[j];
            if (!opv_in[j]) begin
                if (alu_wb_valid && alu_wb_tag == opd_in[j][TW-1:0]) begin
                    opv_res[j] = 1'b1;
                    opd_res[j] = alu_wb_data;
                end else if (mem_wb_valid && mem_wb_tag == opd_in[j][TW-1:0]) begin
                    opv_res[j] = 1'b1;
                    opd_res[j] = mem_wb_data;
                end else if (st_arr[opd_in[j][TW-1:0]] == ST_DONE) begin
                    opv_res[j] = 1'b1;
                    opd_res[j] = res_arr[opd_in[j][TW-1:0]];
                end
            end
        end
    end

    assign koff = kill_tag - head;
    assign pop  = (st_arr[head] == ST_DONE) || (st_arr[head] == ST_KILL);

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [TW-1:0] ioff;
        assign ioff       = TW'(g) - head;
        assign ins_we[g]  = push && (tail == TW'(g));
        assign kill_go[g] = kill_valid && (st_arr[g] != ST_EMPTY) && (ioff > koff);
        assign cmt_go[g]  = pop && (head == TW'(g));
        assign disp_go[g] = (alu_hit && alu_issue_ack && alu_sel == TW'(g)) ||
                            (mem_hit && mem_issue_ack && mem_sel == TW'(g));
        assign alu_req[g] = (st_arr[g] == ST_WAIT) && av_arr[g] && bv_arr[g] && !op_arr[g][OPW-1];
        assign mem_req[g] = (st_arr[g] == ST_WAIT) && av_arr[g] && bv_arr[g] &&  op_arr[g][OPW-1];

        rob_slot #(.DW(DW), .OPW(OPW), .RAW(RAW), .TW(TW), .IDX(g)) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .ins_we (ins_we[g]),
            .ins_op (ins_op),
            .ins_dst(ins_dst),
            .ins_av (opv_res[0]),
            .ins_ad (opd_res[0]),
            .ins_bv (opv_res[1]),
            .ins_bd (opd_res[1]),
            .wa_v   (alu_wb_valid),
            .wa_tag (alu_wb_tag),
            .wa_d   (alu_wb_data),
            .wm_v   (mem_wb_valid),
            .wm_tag (mem_wb_tag),
            .wm_d   (mem_wb_data),
            .disp_go(disp_go[g]),
            .kill_go(kill_go[g]),
            .cmt_go (cmt_go[g]),
            .st     (st_arr[g]),
            .op     (op_arr[g]),
            .dst    (dst_arr[g]),
            .av     (av_arr[g]),
            .ad     (ad_arr[g]),
            .bv     (bv_arr[g]),
            .bd     (bd_arr[g]),
            .res    (res_arr[g])
        );
    end

    rob_oldest #(.N(DEPTH), .TW(TW)) u_pick_alu (
        .req (alu_req),
        .base(head),
        .hit (alu_hit),
        .sel (alu_sel)
    );

    rob_oldest #(.N(DEPTH), .TW(TW)) u_pick_mem (
        .req (mem_req),
        .base(head),
        .hit (mem_hit),
        .sel (mem_sel)
    );

    // outputs
    always_comb begin
        alu_issue_valid = alu_hit;
        alu_issue_tag   = alu_sel;
        alu_issue_op    = op_arr[alu_sel];
        alu_issue_a     = ad_arr[alu_sel];
        alu_issue_b     = bd_arr[alu_sel];
        mem_issue_valid = mem_hit;
        mem_issue_tag   = mem_sel;
        mem_issue_op    = op_arr[mem_sel];
        mem_issue_a     = ad_arr[mem_sel];
        mem_issue_b     = bd_arr[mem_sel];
        retire_valid    = pop;
        rf_we           = (st_arr[head] == ST_DONE);
        rf_waddr        = dst_arr[head];
        rf_wdata        = res_arr[head];
    end
endmodule

// File: rtl/rob_chk.sv
module rob_chk #(
    parameter int DEPTH = 8,
    parameter int TW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ins_valid,
    input logic          ins_ready,
    input logic          kill_valid,
    input logic          alu_issue_valid,
    input logic [TW-1:0] alu_issue_tag,
    input logic          alu_issue_ack,
    input logic          mem_issue_valid,
    input logic [TW-1:0] mem_issue_tag,
    input logic          rf_we,
    input logic          retire_valid,
    input logic [CW-1:0] occ
);
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CW'(DEPTH));

    p_full_refuse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == CW'(DEPTH)) |-> !ins_ready);

    p_occ_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && ins_ready && !retire_valid) |=> (occ == $past(occ) + 1'b1));

    p_kill_blocks_ins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        kill_valid |-> !ins_ready);

    p_write_on_retire_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> retire_valid);

    p_ports_distinct_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_issue_valid && mem_issue_valid) |-> (alu_issue_tag != mem_issue_tag));

    p_no_reissue_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_issue_valid && alu_issue_ack) |=>
            !(alu_issue_valid && alu_issue_tag == $past(alu_issue_tag)));
endmodule

bind rob_core rob_chk #(.DEPTH(DEPTH)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ins_valid      (ins_valid),
    .ins_ready      (ins_ready),
    .kill_valid     (kill_valid),
    .alu_issue_valid(alu_issue_valid),
    .alu_issue_tag  (alu_issue_tag),
    .alu_issue_ack  (alu_issue_ack),
    .mem_issue_valid(mem_issue_valid),
    .mem_issue_tag  (mem_issue_tag),
    .rf_we          (rf_we),
    .retire_valid   (retire_valid),
    .occ            (occ)
);

// File: tb/sim_rob_core.sv
module sim_rob_core;
    localparam int DEPTH = 8;
    localparam int DW    = 16;
    localparam int OPW   = 4;
    localparam int RAW   = 5;
    localparam int TW    = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ins_valid = 1'b0;
    logic [OPW-1:0] ins_op = '0;
    logic [RAW-1:0] ins_dst = '0;
    logic ins_a_rdy = 1'b0, ins_b_rdy = 1'b0;
    logic [DW-1:0] ins_a_val = '0, ins_b_val = '0;
    logic ins_ready;
    logic [TW-1:0] ins_tag;
    logic alu_issue_valid, mem_issue_valid;
    logic [TW-1:0] alu_issue_tag, mem_issue_tag;
    logic [OPW-1:0] alu_issue_op, mem_issue_op;
    logic [DW-1:0] alu_issue_a, alu_issue_b, mem_issue_a, mem_issue_b;
    logic alu_issue_ack = 1'b0, mem_issue_ack = 1'b0;
    logic alu_wb_valid = 1'b0, mem_wb_valid = 1'b0;
    logic [TW-1:0] alu_wb_tag = '0, mem_wb_tag = '0;
    logic [DW-1:0] alu_wb_data = '0, mem_wb_data = '0;
    logic kill_valid = 1'b0;
    logic [TW-1:0] kill_tag = '0;
    logic rf_we, retire_valid;
    logic [RAW-1:0] rf_waddr;
    logic [DW-1:0] rf_wdata;

    int checks = 0;
    int errors = 0;
    int q_we[$], q_addr[$], q_data[$];
    int exp_tail = 0;

    always #2 clk = ~clk;

    rob_core #(.DEPTH(DEPTH), .DW(DW), .OPW(OPW), .RAW(RAW)) u0 (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // one clock; inputs change 1 ns after the edge, pulses cleared
    task automatic cyc();
        @(posedge clk);
        #1;
        ins_valid = 1'b0; alu_issue_ack = 1'b0; mem_issue_ack = 1'b0;
        alu_wb_valid = 1'b0; mem_wb_valid = 1'b0; kill_valid = 1'b0;
    endtask

    task automatic set_ins(input int op, input int dst, input bit av, input int ad,
                           input bit bv, input int bd);
        ins_valid = 1'b1; ins_op = OPW'(op); ins_dst = RAW'(dst);
        ins_a_rdy = av; ins_a_val = DW'(ad); ins_b_rdy = bv; ins_b_val = DW'(bd);
        #0;
        chk("R2 ins_ready", int'(ins_ready), 1);
        chk("R2 ins_tag", int'(ins_tag), exp_tail % DEPTH);
        exp_tail++;
    endtask

    task automatic expect_retire(input int we, input int addr, input int data);
        q_we.push_back(we); q_addr.push_back(addr); q_data.push_back(data);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && retire_valid) begin
            if (q_we.size() == 0) begin
                checks++; errors++;
                $display("FAIL R8 unexpected retire actual we %0d expected none", rf_we);
            end else begin
                int we, ad, dt;
                we = q_we.pop_front(); ad = q_addr.pop_front(); dt = q_data.pop_front();
                chk("R8/R9 rf_we", int'(rf_we), we);
                if (we != 0) begin
                    chk("R8 rf_waddr", int'(rf_waddr), ad);
                    chk("R8 rf_wdata", int'(rf_wdata), dt);
                end
            end
        end
    end

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        chk("R1 ins_ready", int'(ins_ready), 1);
        chk("R1 ins_tag", int'(ins_tag), 0);
        chk("R1 alu_issue_valid", int'(alu_issue_valid), 0);
        chk("R1 mem_issue_valid", int'(mem_issue_valid), 0);
        chk("R1 retire_valid", int'(retire_valid), 0);
        chk("R1 rf_we", int'(rf_we), 0);

        // single arithmetic op: R3 R4 R5 R8
        set_ins(1, 3, 1, 5, 1, 7); cyc();
        chk("R4 alu offer", int'(alu_issue_valid), 1);
        chk("R4 alu tag", int'(alu_issue_tag), 0);
        chk("R3 alu a", int'(alu_issue_a), 5);
        chk("R3 alu b", int'(alu_issue_b), 7);
        chk("R4 mem idle", int'(mem_issue_valid), 0);
        alu_issue_ack = 1'b1; cyc();
        chk("R4 no reissue", int'(alu_issue_valid), 0);
        expect_retire(1, 3, 12);
        alu_wb_valid = 1'b1; alu_wb_tag = 0; alu_wb_data = 12; cyc();
        chk("R5 done retires", int'(retire_valid), 1);
        cyc();

        // memory op feeding an arithmetic op: R3 R4 R6
        set_ins(8, 4, 1, 2, 1, 3); cyc();
        set_ins(2, 5, 0, 1, 1, 1); cyc();
        chk("R4 mem offer", int'(mem_issue_valid), 1);
        chk("R4 mem tag", int'(mem_issue_tag), 1);
        chk("R3 waiting not offered", int'(alu_issue_valid), 0);
        mem_issue_ack = 1'b1; cyc();
        expect_retire(1, 4, 40); expect_retire(1, 5, 41);
        mem_wb_valid = 1'b1; mem_wb_tag = 1; mem_wb_data = 40; cyc();
        chk("R6 woken offer", int'(alu_issue_valid), 1);
        chk("R6 woken tag", int'(alu_issue_tag), 2);
        chk("R6 woken a", int'(alu_issue_a), 40);
        alu_issue_ack = 1'b1; cyc();
        alu_wb_valid = 1'b1; alu_wb_tag = 2; alu_wb_data = 41; cyc();
        cyc();

        // oldest-first, in-order retire, capture paths: R4 R7 R8
        set_ins(1, 6, 1, 10, 1, 0); cyc();
        set_ins(1, 7, 1, 20, 1, 0); cyc();
        chk("R4 oldest", int'(alu_issue_tag), 3);
        alu_issue_ack = 1'b1; cyc();
        chk("R4 next oldest", int'(alu_issue_tag), 4);
        alu_issue_ack = 1'b1; cyc();
        expect_retire(1, 6, 100); expect_retire(1, 7, 200);
        expect_retire(1, 8, 77);  expect_retire(1, 9, 78);
        alu_wb_valid = 1'b1; alu_wb_tag = 4; alu_wb_data = 200; cyc();
        chk("R8 head not done idle", int'(retire_valid), 0);
        set_ins(1, 8, 0, 4, 1, 1); cyc();
        chk("R7 done capture offer", int'(alu_issue_tag), 5);
        chk("R7 done capture a", int'(alu_issue_a), 200);
        alu_issue_ack = 1'b1; cyc();
        alu_wb_valid = 1'b1; alu_wb_tag = 5; alu_wb_data = 77;
        set_ins(1, 9, 0, 5, 1, 0); cyc();
        chk("R7 same-cycle offer", int'(alu_issue_tag), 6);
        chk("R7 same-cycle a", int'(alu_issue_a), 77);
        alu_wb_valid = 1'b1; alu_wb_tag = 3; alu_wb_data = 100; cyc();
        alu_issue_ack = 1'b1; cyc();
        alu_wb_valid = 1'b1; alu_wb_tag = 6; alu_wb_data = 78; cyc();
        repeat (4) cyc();

        // kill across the wrap point: R2 R9
        set_ins(1, 10, 1, 1, 1, 1); cyc();
        set_ins(1, 11, 0, 7, 1, 0); cyc();
        chk("R2 wrapped tag", int'(ins_tag), 1);
        set_ins(8, 12, 1, 1, 1, 1); cyc();
        chk("R9 pre-kill mem offer", int'(mem_issue_tag), 1);
        kill_valid = 1'b1; kill_tag = 7; mem_issue_ack = 1'b1;
        ins_valid = 1'b1; ins_op = 1; ins_a_rdy = 1; ins_b_rdy = 1; #0;
        chk("R9 ins_ready during kill", int'(ins_ready), 0);
        cyc();
        chk("R9 refused insert tag", int'(ins_tag), 2);
        chk("R9 killed not offered", int'(mem_issue_valid), 0);
        chk("R9 branch offered", int'(alu_issue_tag), 7);
        expect_retire(1, 10, 5); expect_retire(0, 0, 0); expect_retire(0, 0, 0);
        alu_issue_ack = 1'b1;
        mem_wb_valid = 1'b1; mem_wb_tag = 1; mem_wb_data = 9; cyc();
        alu_wb_valid = 1'b1; alu_wb_tag = 7; alu_wb_data = 5; cyc();
        repeat (4) cyc();
        chk("R9 drained ready", int'(ins_ready), 1);
        chk("R9 drained retire", int'(retire_valid), 0);

        // fill to capacity: R2 R4
        for (int k = 0; k < DEPTH; k++) begin
            set_ins(8, 16 + k, 1, k, 1, 0); cyc();
        end
        chk("R2 full refuse", int'(ins_ready), 0);
        ins_valid = 1'b1; cyc();
        chk("R2 full tag held", int'(ins_tag), 2);
        for (int k = 0; k < DEPTH; k++) expect_retire(1, 16 + k, k * 3);
        for (int k = 0; k < DEPTH; k++) begin
            chk("R4 mem order", int'(mem_issue_tag), (2 + k) % DEPTH);
            mem_issue_ack = 1'b1; cyc();
        end
        for (int k = 0; k < DEPTH; k++) begin
            mem_wb_valid = 1'b1; mem_wb_tag = TW'((2 + k) % DEPTH); mem_wb_data = DW'(k * 3); cyc();
        end
        repeat (12) cyc();
        chk("R8 all retired", q_we.size(), 0);
        finish_run();
    end
endmodule